// File: doc/BRIEF.md
# Programmable Parallel Port Interface

A register-mapped parallel I/O peripheral. It gives a CPU three 8-bit ports (A, B and C) and one control register over an 8-bit three-state data bus. Port C is handled as two 4-bit halves. Each half has its own latch and its own direction. The bus uses active-low chip select, read and write strobes and a 2-bit register address.

Writes are synchronous: a write takes effect on the rising clock edge while chip select and write are low and read is high. Reads are combinational. The data bus is driven for as long as chip select and read are low and write is high.

A word written to the control register is one of two kinds, chosen by its top bit. A mode word sets the direction of the four port groups. A bit command sets or clears a single port C output bit. Each port presents an output value and an output-enable vector toward its pins, and it samples an input vector from them.

Top module: `ppio_top`

## Requirements
- R1: While `rst` is high, and after it is released, every port is an input. All output-enable bits are 0, all output latches are 0, and a read of the control address returns 00h.
- R2: A register write happens only on a clock edge where `cs_n`=0, `wr_n`=0 and `rd_n`=1. The address selects the target: 00 = port A, 01 = port B, 10 = port C, 11 = control. A write with `cs_n`=1 changes nothing.
- R3: A control word with bit 7 = 1 is a mode word. A direction bit of 1 means input: bit 4 sets port A, bit 3 sets port C bits 7:4, bit 1 sets port B, and bit 0 sets port C bits 3:0. The output-enable bits of a group are 1 exactly when that group is an output.
- R4: A mode word with any of bits 6, 5 or 2 set is ignored. Directions and latches stay unchanged.
- R5: A valid mode word clears the output latches of all three ports to 0.
- R6: A control word with bit 7 = 0 is a bit command. Bits 3:1 give the port C bit index, and bit 0 gives the new value (1 sets, 0 clears). Bits 6:4 are ignored. No other port C bit changes, and the directions stay unchanged.
- R7: A read of a port in output mode returns its latch. A read of port B or of a port C half in input mode returns the pins in the same cycle. A read of port A in input mode returns the pins as sampled at the previous clock edge.
- R8: A read of the control address returns 00h.
- R9: The block drives `dq` only while `cs_n`=0, `rd_n`=0 and `wr_n`=1. At all other times `dq` is high impedance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| dq | inout | 8 | Three-state CPU data bus |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin inputs |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enables |

## Verification
All sixteen direction combinations are programmed in turn. Each one uses a different latch pattern and a different pin pattern, so a read that wrongly returns pins instead of the latch (or the reverse) is exposed group by group and half by half. Every port C bit is set and then cleared in a rising-index sweep, with junk in the ignored field, which separates the index decode from the value bit. Mode words with forbidden bits are mixed with deselected writes to show that neither touches state. A pin change made just before a read, with no clock edge in between, separates the sampled port A input from the pass-through inputs of port C.

// File: rtl/ppio_pkg.sv
package ppio_pkg;
   localparam int CW = 8;
   localparam logic [CW-1:0] MODE_AT_RESET = 8'h9B;

   typedef enum logic [1:0] {
      SEL_A   = 2'd0,
      SEL_B   = 2'd1,
      SEL_C   = 2'd2,
      SEL_CTL = 2'd3
   } ppio_sel_e;

   typedef struct packed {
      logic a_in;
      logic chi_in;
      logic b_in;
      logic clo_in;
   } ppio_dir_t;

   function automatic logic mode_word_ok(input logic [CW-1:0] w);
      return w[7] && (w[6:5] == 2'b00) && !w[2];
   endfunction

   function automatic ppio_dir_t mode_to_dir(input logic [CW-1:0] w);
      ppio_dir_t d;
      d.a_in   = w[4];
      d.chi_in = w[3];
      d.b_in   = w[1];
      d.clo_in = w[0];
      return d;
   endfunction
endpackage

// File: rtl/ppio_busif.sv
module ppio_busif #(
   parameter int AW = 2
) (
   input  logic           cs_n,
   input  logic           rd_n,
   input  logic           wr_n,
   input  logic [AW-1:0]  addr,
   output logic [(1<<AW)-1:0] wr_sel,
   output logic           rd_act
);
   localparam int NT = 1 << AW;

   logic wr_act;
   assign wr_act = !cs_n && !wr_n && rd_n;
   assign rd_act = !cs_n && !rd_n && wr_n;

   for (genvar t = 0; t < NT; t++) begin : g_sel
      assign wr_sel[t] = wr_act && (addr == AW'(t));
   end
endmodule

// File: rtl/ppio_ctrl.sv
module ppio_ctrl
   import ppio_pkg::*;
#(
   parameter int W = 8
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  ctl_wr,
   input  logic [W-1:0]          wdata,
   output ppio_dir_t             dir,
   output logic                  clr_all,
   output logic                  bit_we,
   output logic [$clog2(W)-1:0]  bit_idx,
   output logic                  bit_val
);
   localparam int IW = $clog2(W);

   logic [W-1:0] mode_q;
   logic         is_mode;

   assign is_mode = ctl_wr && wdata[W-1];
   assign clr_all = is_mode && mode_word_ok(wdata);
   assign bit_we  = ctl_wr && !wdata[W-1];
   assign bit_idx = wdata[IW:1];
   assign bit_val = wdata[0];

   always_ff @(posedge clk) begin
      if (rst)          mode_q <= MODE_AT_RESET;
      else if (clr_all) mode_q <= wdata;
   end

   assign dir = mode_to_dir(mode_q);
endmodule

// File: rtl/ppio_port.sv
module ppio_port #(
   parameter int W      = 8,
   parameter bit IN_REG = 1'b0,
   parameter bit BIT_EN = 1'b0
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           clr,
   input  logic                           wr,
   input  logic [W-1:0]                   wdata,
   input  logic                           dir_in,
   input  logic                           bit_we,
   input  logic [(W>1?$clog2(W):1)-1:0]   bit_idx,
   input  logic                           bit_val,
   input  logic [W-1:0]                   pin_in,
   output logic [W-1:0]                   pin_out,
   output logic [W-1:0]                   pin_oe,
   output logic [W-1:0]                   rd_data
);
   logic [W-1:0] lat_q;
   logic [W-1:0] in_view;

   always_ff @(posedge clk) begin
      if (rst || clr)  lat_q <= '0;
      else if (wr)     lat_q <= wdata;
      else if (BIT_EN && bit_we) lat_q[bit_idx] <= bit_val;
   end

   if (IN_REG) begin : g_inreg
      logic [W-1:0] in_q;
      always_ff @(posedge clk) begin
         if (rst) in_q <= '0;
         else     in_q <= pin_in;
      end
      assign in_view = in_q;
   end else begin : g_inpass
      assign in_view = pin_in;
   end

   assign pin_out = lat_q;
   assign pin_oe  = {W{!dir_in}};
   assign rd_data = dir_in ? in_view : lat_q;
endmodule

// File: rtl/ppio_top.sv
module ppio_top
   import ppio_pkg::*;
#(
   parameter int W  = 8,
   parameter int AW = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         cs_n,
   input  logic         rd_n,
   input  logic         wr_n,
   input  logic [AW-1:0] addr,
   inout  wire  [W-1:0] dq,
   input  logic [W-1:0] pa_in,
   output logic [W-1:0] pa_out,
   output logic [W-1:0] pa_oe,
   input  logic [W-1:0] pb_in,
   output logic [W-1:0] pb_out,
   output logic [W-1:0] pb_oe,
   input  logic [W-1:0] pc_in,
   output logic [W-1:0] pc_out,
   output logic [W-1:0] pc_oe
);
   localparam int H  = W / 2;
   localparam int IW = $clog2(W);
   localparam int NT = 1 << AW;

   initial begin
      assert (W == CW) else $error("ppio_top: W must equal the control word width");
      assert (AW == 2) else $error("ppio_top: AW must be 2");
   end

   logic [NT-1:0]  wr_sel;
   logic           bus_oe;
   ppio_dir_t      dir;
   logic           clr_all, bit_we, bit_val;
   logic [IW-1:0]  bit_idx;
   logic [W-1:0]   rd_a, rd_b, rd_c, rd_mux;
   logic [W-1:0]   wdata;

   assign wdata = dq;

   ppio_busif #(.AW(AW)) u_bus (
      .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
      .wr_sel(wr_sel), .rd_act(bus_oe)
   );

   ppio_ctrl #(.W(W)) u_ctl (
      .clk(clk), .rst(rst), .ctl_wr(wr_sel[SEL_CTL]), .wdata(wdata),
      .dir(dir), .clr_all(clr_all), .bit_we(bit_we),
      .bit_idx(bit_idx), .bit_val(bit_val)
   );

   ppio_port #(.W(W), .IN_REG(1'b1), .BIT_EN(1'b0)) u_pa (
      .clk(clk), .rst(rst), .clr(clr_all), .wr(wr_sel[SEL_A]), .wdata(wdata),
      .dir_in(dir.a_in), .bit_we(1'b0), .bit_idx('0), .bit_val(1'b0),
      .pin_in(pa_in), .pin_out(pa_out), .pin_oe(pa_oe), .rd_data(rd_a)
   );

   ppio_port #(.W(W), .IN_REG(1'b0), .BIT_EN(1'b0)) u_pb (
      .clk(clk), .rst(rst), .clr(clr_all), .wr(wr_sel[SEL_B]), .wdata(wdata),
      .dir_in(dir.b_in), .bit_we(1'b0), .bit_idx('0), .bit_val(1'b0),
      .pin_in(pb_in), .pin_out(pb_out), .pin_oe(pb_oe), .rd_data(rd_b)
   );

   for (genvar h = 0; h < 2; h++) begin : g_pc
      logic half_we;
      assign half_we = bit_we && (bit_idx[IW-1] == h[0]);
      ppio_port #(.W(H), .IN_REG(1'b0), .BIT_EN(1'b1)) u_half (
         .clk(clk), .rst(rst), .clr(clr_all), .wr(wr_sel[SEL_C]),
         .wdata(wdata[h*H +: H]),
         .dir_in(h == 0 ? dir.clo_in : dir.chi_in),
         .bit_we(half_we), .bit_idx(bit_idx[IW-2:0]), .bit_val(bit_val),
         .pin_in(pc_in[h*H +: H]), .pin_out(pc_out[h*H +: H]),
         .pin_oe(pc_oe[h*H +: H]), .rd_data(rd_c[h*H +: H])
      );
   end

   always_comb begin
      case (addr)
         SEL_A:   rd_mux = rd_a;
         SEL_B:   rd_mux = rd_b;
         SEL_C:   rd_mux = rd_c;
         default: rd_mux = '0;
      endcase
   end

   assign dq = bus_oe ? rd_mux : 'z;
endmodule

// File: rtl/ppio_chk.sv
module ppio_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst,
   input logic         cs_n,
   input logic         rd_n,
   input logic         wr_n,
   input logic [1:0]   addr,
   input logic [W-1:0] dq,
   input logic         bus_oe,
   input logic [W-1:0] pa_out,
   input logic [W-1:0] pb_out,
   input logic [W-1:0] pc_out,
   input logic [W-1:0] pa_oe,
   input logic [W-1:0] pb_oe,
   input logic [W-1:0] pc_oe
);
   logic wr_cyc, ctl_wr;
   assign wr_cyc = !cs_n && !wr_n && rd_n;
   assign ctl_wr = wr_cyc && (addr == 2'd3);

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !wr_cyc |=> $stable(pa_out) && $stable(pb_out) && $stable(pc_out)
                  && $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe));

   // R5
   mode_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (ctl_wr && dq[7] && dq[6:5] == 2'b00 && !dq[2])
      |=> pa_out == '0 && pb_out == '0 && pc_out == '0);

   // R4
   bad_mode_chk: assert property (@(posedge clk) disable iff (rst)
      (ctl_wr && dq[7] && (dq[6:5] != 2'b00 || dq[2]))
      |=> $stable(pa_out) && $stable(pb_out) && $stable(pc_out)
          && $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe));

   // R6
   single_bit_chk: assert property (@(posedge clk) disable iff (rst)
      (ctl_wr && !dq[7])
      |=> $countones(pc_out ^ $past(pc_out)) <= 1 && $stable(pa_out)
          && $stable(pb_out) && $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe));

   // R9
   bus_drive_chk: assert property (@(posedge clk) disable iff (rst)
      bus_oe |-> !cs_n && !rd_n && wr_n);
endmodule

bind ppio_top ppio_chk #(.W(W)) u_chk (
   .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
   .addr(addr), .dq(dq), .bus_oe(bus_oe),
   .pa_out(pa_out), .pb_out(pb_out), .pc_out(pc_out),
   .pa_oe(pa_oe), .pb_oe(pb_oe), .pc_oe(pc_oe)
);

// File: tb/sim_ppio_top.sv
`timescale 1ns/1ps
module sim_ppio_top;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [1:0] addr = 2'd0;
   logic [7:0] dq_drv = 8'h00;
   logic drv = 1'b0;
   wire  [7:0] dq;
   logic [7:0] pa_in = 0, pb_in = 0, pc_in = 0;
   logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
   int checks = 0, errors = 0;
   bit done = 1'b0;

   assign dq = drv ? dq_drv : 'z;
   always #2.5 clk = ~clk;

   ppio_top u0 (
      .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .addr(addr), .dq(dq),
      .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
      .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
      .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, input logic sel_n = 1'b0);
      @(negedge clk);
      addr = a; dq_drv = d; drv = 1'b1; cs_n = sel_n; wr_n = 1'b0;
      @(negedge clk);
      cs_n = 1'b1; wr_n = 1'b1; drv = 1'b0;
   endtask

   task automatic bus_rd(input logic [1:0] a, output logic [7:0] v);
      @(negedge clk);
      addr = a; cs_n = 1'b0; rd_n = 1'b0;
      #1 v = dq;
      cs_n = 1'b1; rd_n = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] v, pat, pins, exp_c, exp_oe_c;
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk("R1 pa_oe", pa_oe, 8'h00);
      chk("R1 pb_oe", pb_oe, 8'h00);
      chk("R1 pc_oe", pc_oe, 8'h00);
      chk("R1 latches", pa_out | pb_out | pc_out, 8'h00);
      bus_rd(2'd3, v);
      chk("R1 R8 control read", v, 8'h00);

      // R3 R5 R7 sweep of all direction combinations
      for (int m = 0; m < 16; m++) begin
         logic [7:0] word;
         word = {3'b100, m[3], m[2], 1'b0, m[1], m[0]};
         bus_wr(2'd3, word);
         chk("R5 cleared", pa_out | pb_out | pc_out, 8'h00);
         exp_oe_c = {{4{~m[2]}}, {4{~m[0]}}};
         chk("R3 oe", {pa_oe[0], pb_oe[0], pc_oe[7], pc_oe[0]},
             {~m[3], ~m[1], ~m[2], ~m[0]});
         chk("R3 pc_oe", pc_oe, exp_oe_c);
         pat  = 8'(m * 8'h11) ^ 8'h5A;
         pins = 8'(8'hC3 + m * 7);
         @(negedge clk);
         pa_in = pins; pb_in = ~pins; pc_in = pins ^ 8'h3C;
         bus_wr(2'd0, pat);
         // R9 block leaves the bus to the writer during a write
         chk("R9 R2 pa_out", pa_out, pat);
         bus_wr(2'd1, ~pat);
         bus_wr(2'd2, pat ^ 8'hF0);
         bus_rd(2'd0, v);
         chk("R7 read A", v, m[3] ? pins : pat);
         bus_rd(2'd1, v);
         chk("R7 read B", v, m[1] ? ~pins : ~pat);
         exp_c = ((pins ^ 8'h3C) & ~exp_oe_c) | ((pat ^ 8'hF0) & exp_oe_c);
         bus_rd(2'd2, v);
         chk("R7 read C", v, exp_c);
      end

      // R6 bit sweep, all outputs
      bus_wr(2'd3, 8'h80);
      exp_c = 8'h00;
      for (int i = 0; i < 8; i++) begin
         bus_wr(2'd3, {1'b0, 3'(i + 5), i[2:0], 1'b1});
         exp_c[i] = 1'b1;
         chk("R6 set", pc_out, exp_c);
      end
      for (int i = 0; i < 8; i++) begin
         bus_wr(2'd3, {1'b0, 3'(7 - i), i[2:0], 1'b0});
         exp_c[i] = 1'b0;
         chk("R6 clear", pc_out, exp_c);
         chk("R6 dirs kept", pa_oe & pb_oe & pc_oe, 8'hFF);
      end
      bus_wr(2'd3, 8'h0B);
      bus_rd(2'd2, v);
      chk("R6 R7 readback", v, 8'h20);

      // R4 forbidden mode words
      bus_wr(2'd0, 8'h3C);
      foreach (v[k]) begin end
      bus_wr(2'd3, 8'hA0); chk("R4 bit5", pa_out, 8'h3C);
      bus_wr(2'd3, 8'hDB); chk("R4 bit6", pa_oe, 8'hFF);
      bus_wr(2'd3, 8'h84); chk("R4 bit2", pa_out, 8'h3C);
      chk("R4 pc kept", pc_out, 8'h20);

      // R2 deselected write
      bus_wr(2'd0, 8'h77, 1'b1);
      chk("R2 cs high", pa_out, 8'h3C);
      bus_wr(2'd3, 8'h9B, 1'b1);
      chk("R2 cs high mode", pa_oe, 8'hFF);

      // R7 port A sampled vs port C pass-through
      bus_wr(2'd3, 8'h99);
      @(negedge clk);
      pa_in = 8'h11; pc_in = 8'h22;
      @(negedge clk);
      pa_in = 8'hE7; pc_in = 8'hB4;
      addr = 2'd0; cs_n = 1'b0; rd_n = 1'b0;
      #1 chk("R7 A sampled", dq, 8'h11);
      addr = 2'd2;
      #0.5 chk("R7 C pass-through", dq, 8'hB4);
      cs_n = 1'b1; rd_n = 1'b1;
      bus_rd(2'd0, v);
      chk("R7 A after edge", v, 8'hE7);
      bus_rd(2'd3, v);
      chk("R8 control read", v, 8'h00);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule